// File: doc/BRIEF.md
# Delay-Tap Clock Recovery Tracker

This block keeps a bit-rate sampling clock in the middle of the incoming data eye. It never retunes an oscillator. It steers the select code of an external tapped delay line that shifts the one reference-derived bit clock. In each bit period the receive front end gives the block three samples taken around the current tap: one early, one at the centre and one late. At each data transition the block decides whether the sampling point is ahead of the eye centre or behind it. It filters those decisions and moves the delay code one tap at a time. The code wraps around, so a steady frequency offset between the far transmitter and the local reference (up to ±200 ppm, two ±100 ppm ends) is followed for as long as it lasts.

The sample triple arrives as a stream beat marked by `smp_valid`. The block has no back-pressure. It accepts every valid beat, and cycles with `smp_valid` low are gaps that change nothing. The recovered bit leaves as a stream beat on `bit_valid`/`bit_data` one clock after its input beat. It has no ready signal, so the consumer must take every beat. `tap_sel` and `locked` are plain status levels. In a long run of identical bits there are no corrections, and the sampling point drifts by the ppm offset. The run length a link can tolerate therefore depends on how accurate the reference clocks are.

Top module: `dr_tracker`

## Requirements
- R1: Reset state: after reset `tap_sel` = 0, `locked` = 0 and `bit_valid` = 0.
- R2: Recovered bit: a beat with `smp_valid`=1 makes `bit_valid`=1 and `bit_data` equal that beat's `smp_mid` in the next clock. Otherwise `bit_valid` is 0.
- R3: A beat counts as a transition only when its `smp_mid` differs from the `smp_mid` of the previous valid beat (this is 0 after reset). Non-transition beats never change the vote count or the tap.
- R4: Classification at a transition: `smp_early`==`smp_mid` with `smp_late`!=`smp_mid` is a "late" vote (counts −1). `smp_late`==`smp_mid` with `smp_early`!=`smp_mid` is an "early" vote (counts +1). If both side samples agree with the centre, or both disagree with it, there is no vote.
- R5: The net vote count moves the tap only when it reaches +8 (tap +1) or −8 (tap −1). The count then returns to 0, and opposite votes cancel.
- R6: The 5-bit tap code wraps: +1 from 31 gives 0 and −1 from 0 gives 31.
- R7: The tap changes by at most one step per clock, and only on a valid beat.
- R8: `locked` rises on the 64th counted transition.
- R9: When two consecutive tap steps go in the same direction, the transition count toward lock restarts from 0. Steps that alternate in direction do not restart it.
- R10: 256 consecutive valid beats without a transition clear `locked` and restart the transition count.
- R11: Cycles with `smp_valid`=0 leave the tap, vote count, lock state and previous-centre value unchanged, and they produce no output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample triple valid for this bit period |
| smp_early | input | 1 | Sample taken before the centre point |
| smp_mid | input | 1 | Centre sample (data decision) |
| smp_late | input | 1 | Sample taken after the centre point |
| bit_valid | output | 1 | Recovered bit beat valid |
| bit_data | output | 1 | Recovered data bit |
| tap_sel | output | 5 | Delay-line tap select code |
| locked | output | 1 | Tracking lock indicator |

## Verification
The bench feeds exactly seven votes and then the eighth to check the threshold. A filter with an off-by-one limit would step a beat early or late. It drives the code downward across zero and upward across 31 to catch a saturating or badly wrapped accumulator. It feeds vote-shaped triples without a centre change, ambiguous triples and gap cycles, then adds a single real vote; any of those that were wrongly counted would already have produced a step. For lock it checks the 63rd and 64th transitions and the 255th and 256th idle beats. It also compares same-direction and alternating step pairs, which catches a monitor that ignores step history or restarts on every step.

// File: rtl/dr_tracker_pkg.sv
package dr_tracker_pkg;
  typedef enum logic [1:0] {
    VOTE_NONE  = 2'd0,
    VOTE_EARLY = 2'd1,
    VOTE_LATE  = 2'd2
  } vote_e;
endpackage

// File: rtl/dr_phase_detect.sv
module dr_phase_detect
  import dr_tracker_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  valid,
  input  logic  s_early,
  input  logic  s_mid,
  input  logic  s_late,
  output logic  trans,
  output vote_e vote
);
  logic prev_mid;

  // previous centre value only advances on accepted beats
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prev_mid <= 1'b0;
    else if (valid) prev_mid <= s_mid;
  end

  always_comb begin
    trans = valid && (s_mid != prev_mid);
    vote  = VOTE_NONE;
    if (trans) begin
      if ((s_early == s_mid) && (s_late != s_mid))      vote = VOTE_LATE;
      else if ((s_late == s_mid) && (s_early != s_mid)) vote = VOTE_EARLY;
    end
  end
endmodule

// File: rtl/dr_vote_filter.sv
module dr_vote_filter
  import dr_tracker_pkg::*;
#(
  parameter int VOTE_LIMIT = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  vote_e vote,
  output logic  step_up,
  output logic  step_dn
);
  localparam int CW = $clog2(VOTE_LIMIT) + 2;
  localparam logic signed [CW-1:0] LIM_P = CW'(VOTE_LIMIT);
  localparam logic signed [CW-1:0] LIM_N = -LIM_P;
  localparam logic signed [CW-1:0] ONE   = CW'(1);

  logic signed [CW-1:0] acc, acc_nxt;

  always_comb begin
    acc_nxt = acc;
    if (vote == VOTE_EARLY)     acc_nxt = acc + ONE;
    else if (vote == VOTE_LATE) acc_nxt = acc - ONE;
    step_up = (vote == VOTE_EARLY) && (acc_nxt == LIM_P);
    step_dn = (vote == VOTE_LATE)  && (acc_nxt == LIM_N);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acc <= '0;
    else if (step_up || step_dn) acc <= '0;
    else if (vote != VOTE_NONE)  acc <= acc_nxt;
  end
endmodule

// File: rtl/dr_lock_monitor.sv
module dr_lock_monitor #(
  parameter int LOCK_TRANS = 64,
  parameter int IDLE_LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic trans,
  input  logic step_up,
  input  logic step_dn,
  output logic locked
);
  localparam int TW = $clog2(LOCK_TRANS + 1);
  localparam int IW = $clog2(IDLE_LIMIT);
  localparam logic [TW-1:0] T_MAX  = TW'(LOCK_TRANS);
  localparam logic [IW-1:0] I_LAST = IW'(IDLE_LIMIT - 1);

  logic [TW-1:0] tcnt;
  logic [IW-1:0] icnt;
  logic          have_last, last_up;
  logic          step, repeat_dir;

  assign step       = step_up || step_dn;
  assign repeat_dir = step && have_last && (last_up == step_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt      <= '0;
      icnt      <= '0;
      have_last <= 1'b0;
      last_up   <= 1'b0;
      locked    <= 1'b0;
    end else if (valid) begin
      if (trans) begin
        icnt <= '0;
        if (repeat_dir) begin
          tcnt <= '0;
        end else if (tcnt != T_MAX) begin
          tcnt <= tcnt + TW'(1);
          if (tcnt + TW'(1) == T_MAX) locked <= 1'b1;
        end
        if (step) begin
          have_last <= 1'b1;
          last_up   <= step_up;
        end
      end else if (icnt == I_LAST) begin
        icnt   <= '0;
        tcnt   <= '0;
        locked <= 1'b0;
      end else begin
        icnt <= icnt + IW'(1);
      end
    end
  end
endmodule

// File: rtl/dr_tracker.sv
module dr_tracker
  import dr_tracker_pkg::*;
#(
  parameter int TAP_W      = 5,
  parameter int VOTE_LIMIT = 8,
  parameter int LOCK_TRANS = 64,
  parameter int IDLE_LIMIT = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             smp_early,
  input  logic             smp_mid,
  input  logic             smp_late,
  output logic             bit_valid,
  output logic             bit_data,
  output logic [TAP_W-1:0] tap_sel,
  output logic             locked
);
  logic  trans, step_up, step_dn;
  vote_e vote;

  dr_phase_detect pd_i (
    .clk(clk), .rst_n(rst_n), .valid(smp_valid),
    .s_early(smp_early), .s_mid(smp_mid), .s_late(smp_late),
    .trans(trans), .vote(vote)
  );

  dr_vote_filter #(.VOTE_LIMIT(VOTE_LIMIT)) vf_i (
    .clk(clk), .rst_n(rst_n), .vote(vote),
    .step_up(step_up), .step_dn(step_dn)
  );

  dr_lock_monitor #(.LOCK_TRANS(LOCK_TRANS), .IDLE_LIMIT(IDLE_LIMIT)) lm_i (
    .clk(clk), .rst_n(rst_n), .valid(smp_valid), .trans(trans),
    .step_up(step_up), .step_dn(step_dn), .locked(locked)
  );

  // tap accumulator wraps naturally at 2**TAP_W
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tap_sel <= '0;
    else if (step_up) tap_sel <= tap_sel + TAP_W'(1);
    else if (step_dn) tap_sel <= tap_sel - TAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
    end else begin
      bit_valid <= smp_valid;
      if (smp_valid) bit_data <= smp_mid;
    end
  end
endmodule

// File: rtl/dr_tracker_chk.sv
module dr_tracker_chk #(
  parameter int TAP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             smp_mid,
  input logic             bit_valid,
  input logic             bit_data,
  input logic [TAP_W-1:0] tap_sel,
  input logic             locked
);
  logic ck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ck_prev <= 1'b0;
    else if (smp_valid) ck_prev <= smp_mid;
  end

  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tap_sel == $past(tap_sel)) || (tap_sel == $past(tap_sel) + TAP_W'(1))
          || (tap_sel == $past(tap_sel) - TAP_W'(1)));

  a_r11_tap_hold_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(tap_sel));

  a_r11_lock_hold_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(locked));

  a_r11_no_beat_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !bit_valid);

  a_r2_bit_follows: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> bit_valid && (bit_data == $past(smp_mid)));

  a_r3_no_move_without_transition: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_mid == ck_prev)) |=> $stable(tap_sel));

  a_r8_lock_needs_transition: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_mid == ck_prev)) |=> !$rose(locked));
endmodule

bind dr_tracker dr_tracker_chk #(.TAP_W(TAP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mid(smp_mid),
  .bit_valid(bit_valid), .bit_data(bit_data), .tap_sel(tap_sel), .locked(locked)
);

// File: tb/dr_tracker_tb_top.sv
module dr_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0, smp_early = 1'b0, smp_mid = 1'b0, smp_late = 1'b0;
  logic       bit_valid, bit_data, locked;
  logic [4:0] tap_sel;

  int n_run = 0, n_fail = 0;
  logic tb_prev = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  dr_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_early(smp_early),
    .smp_mid(smp_mid), .smp_late(smp_late), .bit_valid(bit_valid),
    .bit_data(bit_data), .tap_sel(tap_sel), .locked(locked)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    smp_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tb_prev = 1'b0;
  endtask

  task automatic push(input logic e, input logic m, input logic l);
    smp_valid = 1'b1; smp_early = e; smp_mid = m; smp_late = l;
    @(negedge clk);
    tb_prev = m;
  endtask

  // kind: 0 early vote (+1), 1 late vote (-1), 2 neutral transition, 3 no transition
  task automatic beat(input int kind, input int n);
    for (int i = 0; i < n; i++) begin
      logic m;
      m = (kind == 3) ? tb_prev : ~tb_prev;
      case (kind)
        0:       push(~m, m, m);
        1:       push(m, m, ~m);
        2:       push(m, m, m);
        default: push(~m, m, m);
      endcase
    end
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      smp_valid = 1'b0; smp_early = ~smp_early; smp_mid = ~smp_mid; smp_late = ~smp_late;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 tap", tap_sel, 0);
    check("R1 locked", locked, 0);
    check("R1 bit_valid", bit_valid, 0);
  endtask

  task automatic t_bitpath();
    logic pat [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
    do_reset();
    for (int i = 0; i < 4; i++) begin
      push(pat[i], pat[i], pat[i]);
      check("R2 bit_valid", bit_valid, 1);
      check("R2 bit_data", bit_data, pat[i]);
    end
    gap(1);
    check("R11 no beat in gap", bit_valid, 0);
  endtask

  task automatic t_threshold();
    do_reset();
    beat(0, 7);
    check("R5 seven votes no step", tap_sel, 0);
    beat(0, 1);
    check("R5 R4 eighth early vote steps up", tap_sel, 1);
    beat(0, 7);
    check("R5 count cleared after step", tap_sel, 1);
  endtask

  task automatic t_cancel();
    do_reset();
    beat(0, 7); beat(1, 1); beat(0, 1);
    check("R5 opposite vote cancels", tap_sel, 0);
    beat(0, 1);
    check("R5 net eight steps", tap_sel, 1);
  endtask

  task automatic t_wrap();
    do_reset();
    beat(1, 8);
    check("R6 R4 late votes wrap down to 31", tap_sel, 31);
    do_reset();
    beat(0, 31 * 8);
    check("R6 climb to 31", tap_sel, 31);
    beat(0, 8);
    check("R6 wrap up to 0", tap_sel, 0);
  endtask

  task automatic t_nontrans();
    do_reset();
    beat(0, 7);
    beat(3, 20);
    check("R3 vote-shaped non-transitions ignored", tap_sel, 0);
    beat(0, 1);
    check("R3 count intact after non-transitions", tap_sel, 1);
  endtask

  task automatic t_ambiguous();
    do_reset();
    beat(0, 7);
    for (int i = 0; i < 10; i++) begin
      logic m;
      m = ~tb_prev;
      if (i % 2 == 0) push(m, m, m); else push(~m, m, ~m);
    end
    check("R4 ambiguous triples give no vote", tap_sel, 0);
    beat(0, 1);
    check("R4 count intact after ambiguous", tap_sel, 1);
  endtask

  task automatic t_gaps();
    do_reset();
    beat(0, 7);
    gap(9);
    check("R11 tap held over gaps", tap_sel, 0);
    check("R11 no beat over gaps", bit_valid, 0);
    beat(0, 1);
    check("R11 count held over gaps", tap_sel, 1);
  endtask

  task automatic t_lock();
    do_reset();
    beat(2, 63);
    check("R8 no lock at 63", locked, 0);
    beat(2, 1);
    check("R8 lock at 64", locked, 1);
    beat(3, 255);
    check("R10 still locked at 255 idle", locked, 1);
    beat(3, 1);
    check("R10 lock lost at 256 idle", locked, 0);
    beat(2, 63);
    check("R10 count restarted", locked, 0);
    beat(2, 1);
    check("R8 relock at 64", locked, 1);
  endtask

  task automatic t_same_dir();
    do_reset();
    beat(2, 40); beat(0, 16);
    check("R6 two up steps", tap_sel, 2);
    beat(2, 63);
    check("R9 same-direction steps restart count", locked, 0);
    beat(2, 1);
    check("R9 lock after restart", locked, 1);
    do_reset();
    beat(0, 8); beat(1, 8); beat(0, 8); beat(2, 39);
    check("R9 alternating steps before 64", locked, 0);
    beat(2, 1);
    check("R9 alternating steps keep count", locked, 1);
  endtask

  initial begin
    t_reset();
    t_bitpath();
    t_threshold();
    t_cancel();
    t_wrap();
    t_nontrans();
    t_ambiguous();
    t_gaps();
    t_lock();
    t_same_dir();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule